// File: doc/BRIEF.md
# Receive Polarity Detection and Correction

This block decides whether the differential receive pair of a twisted-pair port has been wired with its two legs swapped, and when it has, it tells the receive datapath to invert the recovered data. It watches two kinds of already-qualified events from neighbouring logic. The first is link pulses, each tagged with its polarity. The second is end-of-packet events, each carrying a flag that says whether the end delimiter was valid and the polarity that delimiter showed.

After reset, or after a link-fail pulse, detection is armed. A first guess at the polarity comes from a run of same-polarity link pulses. End delimiters of received packets then override that guess. Two valid delimiters in a row that agree lock the decision. Once locked, the decision holds until the next link fail or reset.

A strap input turns the correction off, so data is never inverted. An active-low indicator shows whether the applied polarity is normal. The block runs in a single clock domain, and every event input is a strobe that lasts one cycle.

Top module: `rx_polarity_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears: `rx_invert` reads 0 and `pol_ok_n` reads 0 after that edge. Detection is then armed and no decision has been taken.
- R2: While armed, `RUN_LEN` (default 5) consecutive link pulses of the same polarity seed the decision: `rx_invert` becomes 1 if they were negative (`lp_neg`=1) and 0 if positive. A pulse of the other polarity restarts the run at one, and a shorter run changes nothing.
- R3: Once the decision has been seeded from link pulses, further link pulses of either polarity leave `rx_invert` unchanged.
- R4: The first valid-delimiter packet after reset or link fail (`eop_evt`=1, `eop_valid`=1) sets `rx_invert` to `eop_neg`, whatever the previous setting was. This holds whether or not the decision had been seeded.
- R5: After that, a valid-delimiter packet whose polarity matches the current decision locks it. A packet that does not match makes its own polarity the new decision and starts confirmation again.
- R6: An end-of-packet event with `eop_valid`=0 has no effect on the decision.
- R7: Once locked, link pulses and end-of-packet events of any kind leave `rx_invert` unchanged until a link-fail pulse or reset.
- R8: A `link_fail` pulse re-arms detection and keeps the current `rx_invert` value. Other events in that same cycle are dropped, and a fresh run of link pulses or a valid delimiter then decides again.
- R9: `pol_ok_n` is 0 while `rx_invert` is 0 (normal polarity) and 1 while `rx_invert` is 1 (reversed).
- R10: While `corr_dis` is 1, `rx_invert` and `pol_ok_n` read 0 one cycle later. The decision logic keeps tracking events, so clearing `corr_dis` restores the tracked polarity one cycle later.
- R11: An event sampled at a clock edge shows on `rx_invert` at the next clock edge and not before. With no event, `link_fail` or change of `corr_dis`, the outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lp_evt | input | 1 | One-cycle strobe: a qualified link pulse was seen |
| lp_neg | input | 1 | Polarity of that link pulse, 1 = negative |
| eop_evt | input | 1 | One-cycle strobe: a packet ended |
| eop_valid | input | 1 | The packet's end delimiter was valid |
| eop_neg | input | 1 | Polarity of the end delimiter, 1 = negative (reversed) |
| link_fail | input | 1 | One-cycle strobe: link fail occurred, re-arm detection |
| corr_dis | input | 1 | Strap: 1 disables correction (never invert) |
| rx_invert | output | 1 | 1 = invert the internal receive data |
| pol_ok_n | output | 1 | Polarity indicator, low = normal, high = reversed |

## Verification
The assertions check the following on every cycle:
- the link-pulse run counter never reaches its limit;
- a locked decision stays fixed;
- invalid delimiters leave the decision alone;
- link pulses after seeding leave it alone;
- a link-fail pulse always returns the block to the armed state;
- the output register follows the decision, or zero under the strap, with exactly one cycle of delay.

Some behaviour depends on a whole sequence of events, and only the bench scenarios can show it. Examples are a five-pulse negative seed, a broken run that must not seed, a delimiter overriding a seed, a disagree-then-agree lock, and relocking to the opposite polarity after link fail.

// File: rtl/rx_pol_pkg.sv
// Package: shared types for the receive polarity controller.
// Assumes a single clock domain; holds the decision state encoding.
package rx_pol_pkg;

    // Decision progress of the polarity algorithm
    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,   // waiting for a link-pulse run or a first delimiter
        ST_SEEDED = 2'd1,   // seeded from link pulses, awaiting a delimiter
        ST_CONFIRM= 2'd2,   // decided from a delimiter, awaiting agreement
        ST_LOCKED = 2'd3    // two agreeing delimiters seen, frozen
    } pol_state_t;

endpackage

// File: rtl/lp_run_tracker.sv
// Module: lp_run_tracker
// Counts consecutive same-polarity link pulses while enabled and raises a
// one-cycle seed strobe with the run polarity when the run reaches RUN_LEN.
// Assumes RUN_LEN >= 2 and that lp_evt is a one-cycle strobe.
module lp_run_tracker #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,      // armed and no higher-priority event this cycle
    input  logic clear,       // leave armed state: drop the current run
    input  logic lp_evt,
    input  logic lp_neg,
    output logic seed_stb,
    output logic seed_neg
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             run_neg;
    logic             same_pol;

    // Purpose: decide whether this pulse extends the current run
    always_comb begin
        same_pol = (run_cnt != '0) && (lp_neg == run_neg);
        seed_stb = enable && lp_evt && same_pol && (run_cnt == LAST);
        seed_neg = run_neg;
    end

    // Purpose: run length and polarity bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_cnt <= '0;
            run_neg <= 1'b0;
        end else if (enable && lp_evt) begin
            if (seed_stb) begin
                run_cnt <= '0;
            end else if (same_pol) begin
                run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= CNT_W'(1);
                run_neg <= lp_neg;
            end
        end
    end

    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CNT_W'(RUN_LEN)); // R2

    AST_SEED_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        seed_stb |=> run_cnt == '0); // R2

endmodule

// File: rtl/pol_decider.sv
// Module: pol_decider
// Holds the polarity decision and its progress state. Link-fail has top
// priority, then a valid delimiter, then a link-pulse seed. Invalid
// delimiters are ignored. Assumes all event inputs are one-cycle strobes.
module pol_decider
    import rx_pol_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_fail,
    input  logic       eop_evt,
    input  logic       eop_valid,
    input  logic       eop_neg,
    input  logic       lp_evt,
    input  logic       seed_stb,
    input  logic       seed_neg,
    output pol_state_t state,
    output logic       inv_q
);
    logic delim_hit;

    // Purpose: qualify the delimiter event that may steer the decision
    always_comb begin
        delim_hit = eop_evt && eop_valid && !link_fail;
    end

    // Purpose: decision state machine and polarity register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ARMED;
            inv_q <= 1'b0;
        end else if (link_fail) begin
            state <= ST_ARMED;
        end else begin
            unique case (state)
                ST_ARMED, ST_SEEDED: begin
                    if (delim_hit) begin
                        inv_q <= eop_neg;
                        state <= ST_CONFIRM;
                    end else if (seed_stb) begin
                        inv_q <= seed_neg;
                        state <= ST_SEEDED;
                    end
                end
                ST_CONFIRM: begin
                    if (delim_hit) begin
                        if (eop_neg == inv_q) begin
                            state <= ST_LOCKED;
                        end else begin
                            inv_q <= eop_neg;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && !link_fail) |=> (state == ST_LOCKED && $stable(inv_q))); // R7

    AST_INVALID_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_evt && !eop_valid && !lp_evt && !link_fail) |=> $stable(inv_q)); // R6

    AST_SEEDED_IGNORES_LP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEDED && lp_evt && !eop_evt && !link_fail) |=>
        (state == ST_SEEDED && $stable(inv_q))); // R3

    AST_LINKFAIL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail |=> (state == ST_ARMED && $stable(inv_q))); // R8

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_evt && !eop_evt && !link_fail) |=> $stable(inv_q) && $stable(state)); // R11

endmodule

// File: rtl/pol_out_stage.sv
// Module: pol_out_stage
// Registers the applied invert control, forced to zero by the strap,
// and derives the active-low polarity indicator from it.
// Assumes corr_dis is a static or slowly changing strap.
module pol_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic corr_dis,
    input  logic inv_in,
    output logic rx_invert,
    output logic pol_ok_n
);
    logic inv_out_q;

    // Purpose: register the strap-gated invert control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_out_q <= 1'b0;
        end else begin
            inv_out_q <= inv_in && !corr_dis;
        end
    end

    // Purpose: drive outputs, indicator released high when reversed
    always_comb begin
        rx_invert = inv_out_q;
        pol_ok_n  = inv_out_q;
    end

    AST_STRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        corr_dis |=> !inv_out_q); // R10

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_dis |=> inv_out_q == $past(inv_in)); // R11

endmodule

// File: rtl/rx_polarity_ctrl.sv
// Module: rx_polarity_ctrl (top)
// Decides receive-pair polarity from link pulses and end delimiters
// and drives the invert control and the polarity indicator.
// Assumes single clock domain and one-cycle event strobes.
module rx_polarity_ctrl
    import rx_pol_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_evt,
    input  logic lp_neg,
    input  logic eop_evt,
    input  logic eop_valid,
    input  logic eop_neg,
    input  logic link_fail,
    input  logic corr_dis,
    output logic rx_invert,
    output logic pol_ok_n
);
    pol_state_t state;
    logic       inv_q;
    logic       seed_stb;
    logic       seed_neg;
    logic       run_en;
    logic       run_clr;

    // Purpose: link pulses count only while armed and not pre-empted
    always_comb begin
        run_clr = link_fail || (state != ST_ARMED);
        run_en  = (state == ST_ARMED) && !link_fail && !(eop_evt && eop_valid);
    end

    lp_run_tracker #(.RUN_LEN(RUN_LEN)) i_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (run_en),
        .clear    (run_clr),
        .lp_evt   (lp_evt),
        .lp_neg   (lp_neg),
        .seed_stb (seed_stb),
        .seed_neg (seed_neg)
    );

    pol_decider i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_fail (link_fail),
        .eop_evt   (eop_evt),
        .eop_valid (eop_valid),
        .eop_neg   (eop_neg),
        .lp_evt    (lp_evt),
        .seed_stb  (seed_stb),
        .seed_neg  (seed_neg),
        .state     (state),
        .inv_q     (inv_q)
    );

    pol_out_stage i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .corr_dis  (corr_dis),
        .inv_in    (inv_q),
        .rx_invert (rx_invert),
        .pol_ok_n  (pol_ok_n)
    );

endmodule

// File: tb/test_rx_polarity_ctrl.sv
module test_rx_polarity_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_evt = 1'b0, lp_neg = 1'b0;
    logic eop_evt = 1'b0, eop_valid = 1'b0, eop_neg = 1'b0;
    logic link_fail = 1'b0, corr_dis = 1'b0;
    logic rx_invert, pol_ok_n;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    rx_polarity_ctrl i_rx_polarity_ctrl (
        .clk(clk), .rst_n(rst_n), .lp_evt(lp_evt), .lp_neg(lp_neg),
        .eop_evt(eop_evt), .eop_valid(eop_valid), .eop_neg(eop_neg),
        .link_fail(link_fail), .corr_dis(corr_dis),
        .rx_invert(rx_invert), .pol_ok_n(pol_ok_n)
    );

    task automatic expect_out(input logic exp_inv, input string req);
        checks++;
        if (rx_invert !== exp_inv || pol_ok_n !== exp_inv) begin
            errors++;
            $display("FAIL %s: rx_invert=%b pol_ok_n=%b expected %b/%b",
                     req, rx_invert, pol_ok_n, exp_inv, exp_inv);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic link_pulse(input logic neg);
        @(negedge clk); lp_evt = 1'b1; lp_neg = neg;
        @(negedge clk); lp_evt = 1'b0;
    endtask

    task automatic pkt_end(input logic valid, input logic neg);
        @(negedge clk); eop_evt = 1'b1; eop_valid = valid; eop_neg = neg;
        @(negedge clk); eop_evt = 1'b0; eop_valid = 1'b0;
    endtask

    task automatic fail_pulse();
        @(negedge clk); link_fail = 1'b1;
        @(negedge clk); link_fail = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        expect_out(1'b0, "R1 reset");
    endtask

    // R2/R3: broken run, then five negative pulses seed
    task automatic t_seed_neg();
        do_reset();
        for (int i = 0; i < 3; i++) link_pulse(1'b1);
        link_pulse(1'b0);
        for (int i = 0; i < 4; i++) link_pulse(1'b1);
        settle();
        expect_out(1'b0, "R2 run of four no seed");
        link_pulse(1'b1);
        settle();
        expect_out(1'b1, "R2 five negative seed");
        expect_out(1'b1, "R9 indicator high reversed");
        for (int i = 0; i < 6; i++) link_pulse(1'b0);
        settle();
        expect_out(1'b1, "R3 pulses after seed ignored");
    endtask

    // R4/R5/R6/R7: delimiter override, disagree then agree, lock
    task automatic t_delim_lock();
        pkt_end(1'b1, 1'b0);
        settle();
        expect_out(1'b0, "R4 delimiter overrides seed");
        pkt_end(1'b0, 1'b1);
        settle();
        expect_out(1'b0, "R6 invalid delimiter ignored");
        pkt_end(1'b1, 1'b1);
        settle();
        expect_out(1'b1, "R5 disagree replaces");
        pkt_end(1'b1, 1'b1);
        settle();
        expect_out(1'b1, "R5 agree locks");
        pkt_end(1'b1, 1'b0);
        pkt_end(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) link_pulse(1'b0);
        settle();
        expect_out(1'b1, "R7 locked holds");
    endtask

    // R8: relock after link fail to opposite polarity
    task automatic t_relock();
        fail_pulse();
        settle();
        expect_out(1'b1, "R8 link fail keeps value");
        for (int i = 0; i < 5; i++) link_pulse(1'b0);
        settle();
        expect_out(1'b0, "R8 reseed after link fail");
        pkt_end(1'b1, 1'b1);
        pkt_end(1'b1, 1'b1);
        settle();
        expect_out(1'b1, "R8 relocked negative");
        pkt_end(1'b1, 1'b0);
        settle();
        expect_out(1'b1, "R7 relock holds");
    endtask

    // R4/R11: first delimiter without seed, one-cycle latency
    task automatic t_latency();
        do_reset();
        @(negedge clk); eop_evt = 1'b1; eop_valid = 1'b1; eop_neg = 1'b1;
        @(negedge clk); eop_evt = 1'b0; eop_valid = 1'b0;
        expect_out(1'b0, "R11 not before next edge");
        @(negedge clk);
        expect_out(1'b1, "R11 R4 shows after next edge");
        repeat (4) @(negedge clk);
        expect_out(1'b1, "R11 quiet stable");
    endtask

    // R10: strap disables correction, tracking continues
    task automatic t_strap();
        @(negedge clk); corr_dis = 1'b1;
        @(negedge clk);
        expect_out(1'b0, "R10 strap forces normal");
        pkt_end(1'b1, 1'b1);
        settle();
        expect_out(1'b0, "R10 strap still normal");
        @(negedge clk); corr_dis = 1'b0;
        @(negedge clk);
        expect_out(1'b1, "R10 tracked value restored");
    endtask

    initial begin
        t_reset();
        t_seed_neg();
        t_delim_lock();
        t_relock();
        t_latency();
        t_strap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule